// File: doc/BRIEF.md
# Rate-scaled envelope generator

This block shapes the loudness of one operator of an FM synthesizer over time. Key events and a per-sample strobe drive it. Each strobe moves it one step through its phases: rise, fall to a sustain level, an optional slow fade while the key is held, release, and silence. Its output is an attenuation word in which 0 is full volume and 127 is silence. One unit of attenuation is 0.375 dB.

Progress is kept in a 22-bit phase accumulator with one extra overflow bit. The attenuation is the accumulator's top bits, except during the rise, where those bits pass through a logarithmic curve. Every rate is scaled by the note's pitch: the octave and the top frequency-number bit raise the effective rate, so high notes move faster. A key release that lands in the middle of the rise converts the accumulator through the same curve, so the fade starts from the level that could be heard at that moment.

The block contains no total level, key-level scaling or tremolo. Those are added after it.

Top module: `env_gen`

## Requirements
- R1: After reset, `atten` is 127 and `done` is 0. The block sits in an idle settle state with a full-scale accumulator.
- R2: A clock with `key_on` high clears the accumulator and enters the rise phase, whether or not `tick` is high. When both key inputs are high, `key_on` wins.
- R3: State and accumulator advance only on clocks with `tick` high. `atten` changes only on such clocks and takes the value computed from the accumulator before that tick's addition.
- R4: The scale index is 2×`octave`+`fnum_msb` when `rate_scale_en` is 1, and `octave`>>1 when it is 0. The major rate is code + (index>>2), saturated at 15. The minor rate is index & 3.
- R5: A rise code from 1 to 14 adds 3×(minor+4)<<(major+1) per tick. During the rise, `atten` is min(127, curve(acc[21:15])), where curve(0)=128 and curve(i)=trunc(127−128·ln i/ln 128), floored at 0. A rise code of 0 never progresses.
- R6: A rise code of 15 gives `atten`=0 on the first tick and enters the fall phase with a zero accumulator.
- R7: The rise ends on the tick whose addition sets accumulator bit 22. That tick outputs 0, clears the accumulator and starts the fall phase.
- R8: The fall, slow-fade and release phases add (minor+4)<<(major−1) per tick, and a code of 0 adds nothing. Outside the rise, `atten` is min(127, acc>>15).
- R9: The fall stops when the accumulator reaches the sustain threshold, which is (8×`sus_lvl`)<<15, or 128<<15 for code 15. The accumulator is then clamped to that threshold. The block holds there while `hold_type` is 1 and moves to a slow fade at `rel_code` when it is 0.
- R10: The release rate code is 5 when `chan_sustain` is 1. Otherwise it is `rel_code` when `hold_type` is 1, and 7 when `hold_type` is 0.
- R11: A key release during the rise loads curve(acc[21:15])<<15 into the accumulator and enters release.
- R12: The slow-fade or release phase ends when acc>>15 reaches 128. From then on `done` is 1 and `atten` holds 127.
- R13: `key_off` in the settle or finished state has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Sample strobe; one envelope step |
| key_on | input | 1 | Key press event |
| key_off | input | 1 | Key release event |
| atk_code | input | 4 | Rise rate code |
| dec_code | input | 4 | Fall rate code |
| sus_lvl | input | 4 | Sustain level code |
| rel_code | input | 4 | Release rate code |
| hold_type | input | 1 | 1: hold at sustain level; 0: keep fading |
| rate_scale_en | input | 1 | Selects the fine pitch rate scaling |
| chan_sustain | input | 1 | Channel sustain flag; forces a slow release |
| octave | input | 3 | Note octave |
| fnum_msb | input | 1 | Top bit of the frequency number |
| atten | output | 7 | Attenuation, 0 loudest, 127 silent |
| done | output | 1 | Envelope has finished |

## Verification
The hardest state to reach from the ports is a key release in the middle of the rise, with the accumulator at a known position. The stimulus uses a slow rise code with no pitch scaling, so every tick adds a fixed step. After an exact number of ticks the curve index is therefore known. The release is then given the channel sustain rate, which is so slow that the first tick after the release shows the remapped level itself. The three release-rate sources are told apart by releasing from a zero-attenuation fall phase (fall code 0) and counting enough ticks for the three increments to give different levels.

// File: rtl/env_pkg.sv
package env_pkg;

  typedef enum logic [2:0] {
    ST_SETTLE, ST_ATTACK, ST_DECAY, ST_HOLD, ST_SUSDEC, ST_RELEASE, ST_DONE
  } env_state_e;

  // Pitch-dependent rate index (R4)
  function automatic logic [3:0] rate_index(input logic ksr_on, input logic [2:0] oct,
                                            input logic fmsb);
    return ksr_on ? {oct, fmsb} : {2'b00, oct[2:1]};
  endfunction

  // Major rate: code plus upper index bits, saturated
  function automatic logic [3:0] rate_major(input logic [3:0] code, input logic [3:0] idx);
    logic [4:0] s;
    s = {1'b0, code} + {3'b000, idx[3:2]};
    return (s > 5'd15) ? 4'd15 : s[3:0];
  endfunction

  // Rise step per tick (R5)
  function automatic logic [31:0] attack_step(input logic [3:0] code, input logic [3:0] idx);
    logic [3:0] rm;
    logic [4:0] mant;
    rm   = rate_major(code, idx);
    mant = 5'd3 * ({3'b000, idx[1:0]} + 5'd4);
    if (code == 4'd0 || code == 4'd15) return 32'd0;
    return {27'd0, mant} << ({1'b0, rm} + 5'd1);
  endfunction

  // Fall / fade / release step per tick (R8)
  function automatic logic [31:0] decay_step(input logic [3:0] code, input logic [3:0] idx);
    logic [3:0] rm;
    logic [2:0] mant;
    rm   = rate_major(code, idx);
    mant = {1'b0, idx[1:0]} + 3'd4;
    if (code == 4'd0) return 32'd0;
    return {29'd0, mant} << (rm - 4'd1);
  endfunction

  // Sustain threshold in attenuation units (R9)
  function automatic logic [7:0] sustain_units(input logic [3:0] sl);
    return (sl == 4'd15) ? 8'd128 : {1'b0, sl, 3'b000};
  endfunction

endpackage

// File: rtl/env_rate_unit.sv
module env_rate_unit
  import env_pkg::*;
#(
  parameter int ACC_W = 22
) (
  input  logic [3:0]       atk_code,
  input  logic [3:0]       dr_code,
  input  logic             ksr_on,
  input  logic [2:0]       oct,
  input  logic             fmsb,
  output logic [ACC_W-1:0] atk_inc,
  output logic [ACC_W-1:0] dr_inc
);
  logic [3:0]  idx;
  logic [31:0] atk_full, dr_full;

  always_comb begin
    idx      = rate_index(ksr_on, oct, fmsb);
    atk_full = attack_step(atk_code, idx);
    dr_full  = decay_step(dr_code, idx);
    atk_inc  = atk_full[ACC_W-1:0];
    dr_inc   = dr_full[ACC_W-1:0];
  end

  // Steps always fit below the overflow bit (R5, R8)
  always_comb begin
    assert_step_fits_R5: assert (atk_full < (32'd1 << ACC_W) && dr_full < (32'd1 << ACC_W));
  end
endmodule

// File: rtl/env_log_curve.sv
module env_log_curve #(
  parameter int IDX_W = 7,
  parameter int OUT_W = IDX_W + 1
) (
  input  logic [IDX_W-1:0] idx,
  output logic [OUT_W-1:0] val
);
  localparam int DEPTH = 1 << IDX_W;

  logic [OUT_W-1:0] rom [DEPTH];

  // Log curve computed at elaboration (R5, R11)
  for (genvar g = 0; g < DEPTH; g++) begin : g_rom
    localparam real ARG   = (g == 0) ? 1.0 : real'(g);
    localparam real CURVE = real'(DEPTH - 1) - real'(DEPTH) * $ln(ARG) / $ln(real'(DEPTH));
    localparam int  VAL   = (g == 0) ? DEPTH : ((CURVE <= 0.0) ? 0 : $rtoi(CURVE));
    assign rom[g] = OUT_W'(VAL);
  end

  assign val = rom[idx];
endmodule

// File: rtl/env_gen.sv
module env_gen
  import env_pkg::*;
#(
  parameter int ACC_W = 22,
  parameter int ATT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             key_on,
  input  logic             key_off,
  input  logic [3:0]       atk_code,
  input  logic [3:0]       dec_code,
  input  logic [3:0]       sus_lvl,
  input  logic [3:0]       rel_code,
  input  logic             hold_type,
  input  logic             rate_scale_en,
  input  logic             chan_sustain,
  input  logic [2:0]       octave,
  input  logic             fnum_msb,
  output logic [ATT_W-1:0] atten,
  output logic             done
);
  localparam int SHIFT = ACC_W - ATT_W;
  localparam int TOP_W = ATT_W + 1;
  localparam int FULL  = 1 << ATT_W;

  env_state_e       st, st_n;
  logic [ACC_W:0]   acc, acc_n;
  logic [ATT_W-1:0] atten_n;
  logic [3:0]       rate_code;
  logic [ACC_W-1:0] atk_inc, dr_inc;
  logic [TOP_W-1:0] curve_val, top_bits, raw;
  logic [ACC_W:0]   atk_sum, dr_sum, sus_thr;
  // Named internal events
  logic attack_over, decay_hit, reach_full;

  // Rate code chosen for the current phase (R10)
  always_comb begin
    unique case (st)
      ST_SUSDEC:  rate_code = rel_code;
      ST_RELEASE: rate_code = chan_sustain ? 4'd5 : (hold_type ? rel_code : 4'd7);
      default:    rate_code = dec_code;
    endcase
  end

  env_rate_unit #(.ACC_W(ACC_W)) u_rate (
    .atk_code(atk_code), .dr_code(rate_code), .ksr_on(rate_scale_en),
    .oct(octave), .fmsb(fnum_msb), .atk_inc(atk_inc), .dr_inc(dr_inc)
  );

  env_log_curve #(.IDX_W(ATT_W), .OUT_W(TOP_W)) u_curve (
    .idx(acc[ACC_W-1:SHIFT]), .val(curve_val)
  );

  assign top_bits = acc[ACC_W:SHIFT];
  assign atk_sum  = acc + {1'b0, atk_inc};
  assign dr_sum   = acc + {1'b0, dr_inc};
  assign sus_thr  = {sustain_units(sus_lvl), SHIFT'(0)};

  always_comb begin
    st_n = st; acc_n = acc; atten_n = atten; raw = TOP_W'(FULL - 1);
    attack_over = 1'b0; decay_hit = 1'b0; reach_full = 1'b0;
    if (key_on) begin
      st_n = ST_ATTACK; acc_n = '0;
    end else if (key_off && st != ST_SETTLE && st != ST_DONE) begin
      if (st == ST_ATTACK) acc_n = {curve_val, SHIFT'(0)};
      st_n = ST_RELEASE;
    end else if (tick) begin
      unique case (st)
        ST_ATTACK: begin
          raw = curve_val;
          acc_n = atk_sum;
          if (atk_sum[ACC_W] || atk_code == 4'd15) begin
            attack_over = 1'b1; raw = '0; acc_n = '0; st_n = ST_DECAY;
          end
        end
        ST_DECAY: begin
          raw = top_bits;
          acc_n = dr_sum;
          if (dr_sum >= sus_thr) begin
            decay_hit = 1'b1; acc_n = sus_thr;
            st_n = hold_type ? ST_HOLD : ST_SUSDEC;
          end
        end
        ST_HOLD: begin
          raw = top_bits;
          if (!hold_type) st_n = ST_SUSDEC;
        end
        ST_SUSDEC, ST_RELEASE: begin
          raw = top_bits;
          acc_n = dr_sum;
          if (top_bits >= TOP_W'(FULL)) begin
            reach_full = 1'b1; raw = TOP_W'(FULL - 1); st_n = ST_DONE;
          end
        end
        default: raw = TOP_W'(FULL - 1);
      endcase
      atten_n = (raw >= TOP_W'(FULL)) ? ATT_W'(FULL - 1) : raw[ATT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_SETTLE;
      acc   <= (ACC_W+1)'(1) << ACC_W;
      atten <= ATT_W'(FULL - 1);
    end else begin
      st    <= st_n;
      acc   <= acc_n;
      atten <= atten_n;
    end
  end

  assign done = (st == ST_DONE);

  // Key press restarts the rise from zero (R2)
  assert_keyon_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    key_on |=> st == ST_ATTACK && acc == '0);

  // Output moves only on a tick (R3)
  assert_no_tick_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(atten));

  // Rise code 15 jumps to full volume (R6)
  assert_instant_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_ATTACK && tick && !key_on && !key_off && atk_code == 4'd15
      |=> st == ST_DECAY && atten == '0);

  // Hold keeps the accumulator (R9)
  assert_hold_still_R9: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_HOLD && tick && hold_type && !key_on && !key_off
      |=> st == ST_HOLD && $stable(acc));

  // Release during the rise remaps through the curve (R11)
  assert_release_remap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    key_off && !key_on && st == ST_ATTACK
      |=> st == ST_RELEASE && acc == {$past(curve_val), SHIFT'(0)});

  // Finished means silent (R12)
  assert_done_silent_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> atten == ATT_W'(FULL - 1));

  // Key release in settle or finished changes nothing (R13)
  assert_idle_keyoff_R13: assert property (@(posedge clk) disable iff (!rst_n)
    key_off && !key_on && (st == ST_SETTLE || st == ST_DONE) |=> $stable(st));
endmodule

// File: tb/test_env_gen.sv
module test_env_gen;
  logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0, key_on = 1'b0, key_off = 1'b0;
  logic [3:0] atk_code = '0, dec_code = '0, sus_lvl = '0, rel_code = '0;
  logic       hold_type = 1'b1, rate_scale_en = 1'b0, chan_sustain = 1'b0, fnum_msb = 1'b0;
  logic [2:0] octave = '0;
  logic [6:0] atten;
  logic       done;
  int checks = 0, errors = 0, cyc = 0;

  env_gen i_env_gen (
    .clk(clk), .rst_n(rst_n), .tick(tick), .key_on(key_on), .key_off(key_off),
    .atk_code(atk_code), .dec_code(dec_code), .sus_lvl(sus_lvl), .rel_code(rel_code),
    .hold_type(hold_type), .rate_scale_en(rate_scale_en), .chan_sustain(chan_sustain),
    .octave(octave), .fnum_msb(fnum_msb), .atten(atten), .done(done)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog all requirements actual=%0d expected=<100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // Reference arithmetic, written from the requirements
  function automatic int ref_scale(int en, int oct, int msb);
    return (en != 0) ? oct * 2 + msb : oct / 2;
  endfunction
  function automatic int ref_major(int code, int sc);
    return (code + sc / 4 > 15) ? 15 : code + sc / 4;
  endfunction
  function automatic int ref_rise(int code, int sc);
    if (code == 0 || code == 15) return 0;
    return 3 * (sc % 4 + 4) * (2 ** (ref_major(code, sc) + 1));
  endfunction
  function automatic int ref_fall(int code, int sc);
    if (code == 0) return 0;
    return (sc % 4 + 4) * (2 ** (ref_major(code, sc) - 1));
  endfunction
  function automatic int curve_ref(int i);
    real v;
    if (i == 0) return 127;
    v = 127.0 - 128.0 * $log10(real'(i)) / $log10(128.0);
    if (v <= 0.0) return 0;
    return $rtoi(v);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input int ar, input int dr, input int sl, input int rr, input int ht,
                         input int kse, input int oct, input int msb, input int cs);
    atk_code = 4'(ar); dec_code = 4'(dr); sus_lvl = 4'(sl); rel_code = 4'(rr);
    hold_type = 1'(ht); rate_scale_en = 1'(kse); octave = 3'(oct); fnum_msb = 1'(msb);
    chan_sustain = 1'(cs);
  endtask

  task automatic pulse_on();
    key_on = 1'b1; @(negedge clk); key_on = 1'b0;
  endtask
  task automatic pulse_off();
    key_off = 1'b1; @(negedge clk); key_off = 1'b0;
  endtask
  task automatic run_ticks(input int n);
    tick = 1'b1; repeat (n) @(negedge clk); tick = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 reset atten", atten, 127);
    check("R1 reset done", done, 0);
  endtask

  task automatic t_settle_keyoff();
    pulse_off(); run_ticks(300);
    check("R13 key-off in settle atten", atten, 127);
    check("R13 key-off in settle done", done, 0);
  endtask

  task automatic t_no_tick_then_instant();
    set_cfg(15, 0, 15, 0, 1, 0, 0, 0, 0);
    pulse_on(); repeat (10) @(negedge clk);
    check("R3 no tick keeps atten", atten, 127);
    run_ticks(1);
    check("R6 rise code 15 gives 0", atten, 0);
  endtask

  task automatic t_rise_curve_and_remap();
    int inc;
    set_cfg(8, 0, 15, 0, 1, 0, 0, 0, 1);
    inc = ref_rise(8, ref_scale(0, 0, 0));
    pulse_on(); run_ticks(40);
    check("R5 rise curve", atten, curve_ref((39 * inc) >> 15));
    pulse_off(); run_ticks(1);
    check("R11 key-off remap", atten, curve_ref((40 * inc) >> 15));
  endtask

  task automatic t_rise_zero();
    set_cfg(0, 0, 15, 0, 1, 0, 0, 0, 0);
    pulse_on(); run_ticks(50);
    check("R5 rise code 0 stalls", atten, 127);
    check("R5 rise code 0 not done", done, 0);
  endtask

  task automatic t_rise_end();
    set_cfg(8, 15, 15, 0, 1, 0, 0, 0, 0);
    pulse_on(); run_ticks(688);
    check("R7 rise overflow then fall", atten, (4 * ref_fall(15, 0)) >> 15);
  endtask

  task automatic t_fall_sustain();
    int sc, inc;
    set_cfg(15, 12, 2, 15, 1, 1, 7, 1, 0);
    sc = ref_scale(1, 7, 1);
    inc = ref_fall(12, sc);
    pulse_on(); run_ticks(4);
    check("R8 fall step", atten, (2 * inc) >> 15);
    run_ticks(20);
    check("R9 hold at sustain", atten, 2 * 8);
    check("R9 hold not done", done, 0);
  endtask

  task automatic t_fade_finish();
    set_cfg(15, 12, 2, 15, 0, 1, 7, 1, 0);
    pulse_on(); run_ticks(100);
    check("R12 fade finished done", done, 1);
    check("R12 fade finished atten", atten, 127);
    pulse_off(); run_ticks(10);
    check("R13 key-off in finished", done, 1);
  endtask

  task automatic t_sus15();
    set_cfg(15, 15, 15, 0, 1, 0, 0, 0, 0);
    pulse_on(); run_ticks(81);
    check("R9 sustain code 15 atten", atten, 127);
    check("R9 sustain code 15 not done", done, 0);
  endtask

  task automatic release_from_zero(input string req, input int ht, input int cs,
                                   input int kse, input int oct, input int msb,
                                   input int rr, input int code);
    set_cfg(15, 0, 15, rr, ht, kse, oct, msb, cs);
    pulse_on(); run_ticks(1); pulse_off(); run_ticks(257);
    check(req, atten, (256 * ref_fall(code, ref_scale(kse, oct, msb))) >> 15);
  endtask

  task automatic t_release_select();
    release_from_zero("R10 release uses rel_code", 1, 0, 0, 0, 0, 10, 10);
    release_from_zero("R10 release uses code 7", 0, 0, 0, 0, 0, 10, 7);
    release_from_zero("R10 release uses code 5", 1, 1, 0, 0, 0, 10, 5);
  endtask

  task automatic t_scale();
    release_from_zero("R4 fine scaling", 1, 0, 1, 5, 0, 8, 8);
    release_from_zero("R4 coarse scaling", 1, 0, 0, 5, 0, 8, 8);
    release_from_zero("R4 scaling uses fnum bit", 1, 0, 1, 5, 1, 8, 8);
  endtask

  task automatic t_key_priority();
    set_cfg(15, 0, 15, 8, 1, 1, 5, 1, 0);
    key_on = 1'b1; key_off = 1'b1; @(negedge clk); key_on = 1'b0; key_off = 1'b0;
    run_ticks(1);
    check("R2 key_on wins and restarts", atten, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_settle_keyoff();
    t_no_tick_then_instant();
    t_rise_curve_and_remap();
    t_rise_zero();
    t_rise_end();
    t_fall_sustain();
    t_fade_finish();
    t_sus15();
    t_release_select();
    t_scale();
    t_key_priority();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule